// File: doc/BRIEF.md
# Embedded-Operation Status Bit Generator

This block sits between a memory array and its data bus. While an internal write, program or erase cycle runs, it replaces the array byte seen by the host with a status byte. The host can poll that byte to tell when the cycle has ended and whether it failed. Bit 7 shows the complement of the byte being written, or zero during an erase. Bit 6 flips on every read strobe. Bit 5 mirrors the error flag. Bits 4 to 0 pass the array data. When no cycle is running, the array byte passes through untouched.

The block counts write pulses to decide when polling becomes meaningful. The status byte is shown only after the command sequence for the current region and operation has supplied enough pulses. Before that, array data is shown. A separate active-low ready/busy pin reports cycles in the EEPROM region only.

Top module: `opstat_top`

## Requirements
- R1: While `busy_i` is 1, status is valid and `op_i`=0 (program), `dq_o[7]` equals the inverse of `wdata_i[7]`.
- R2: While `busy_i` is 1, status is valid and `op_i`=1 (erase), `dq_o[7]` is 0.
- R3: `dq_o[6]` shows a toggle bit. The toggle bit is 0 in every cycle that follows an edge with `busy_i` at 0. It inverts after every clock edge at which both `busy_i` and `rd_i` are 1.
- R4: While `busy_i` is 0, `dq_o` equals `array_i` on all eight bits.
- R5: While status is valid, `dq_o[5]` equals `err_i`.
- R6: `rb_no` is 0 exactly when `busy_i` is 1 and `rgn_i`=1 (EEPROM). For `rgn_i`=0 (flash) it stays 1.
- R7: `valid_o` is 1 exactly when `busy_i` is 1 and the pulse count has reached its threshold: 4 for flash program, 6 for flash erase, 1 for EEPROM. The count adds one at each edge with `we_i`=1 and saturates at the largest threshold. While `busy_i` is 1 and `valid_o` is 0, `dq_o` equals `array_i`.
- R8: While status is valid, `dq_o[4:0]` equals `array_i[4:0]`.
- R9: Reset clears the pulse count and the toggle bit. An edge where `busy_i` falls from 1 to 0 clears the pulse count, and takes priority over a pulse at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Internal cycle in progress |
| op_i | input | 1 | 0 program/write, 1 erase |
| rgn_i | input | 1 | 0 flash region, 1 EEPROM region |
| wdata_i | input | 8 | Latched byte being written |
| err_i | input | 1 | Internal cycle error flag |
| rd_i | input | 1 | Read strobe, one cycle per read access |
| we_i | input | 1 | Write pulse strobe |
| array_i | input | 8 | Addressed array byte |
| dq_o | output | 8 | Data bus value |
| valid_o | output | 1 | Status byte is being presented |
| rb_no | output | 1 | Ready/busy, low while an EEPROM cycle runs |

## Verification
Random episodes vary the region, the operation, the written byte and the density of pulses and reads. They also vary the error flag. This mix separates program polling from erase polling on bit 7, and separates the three pulse thresholds. Directed runs stop at exactly one pulse below each threshold and at the threshold itself. Back-to-back reads check that bit 6 flips on every strobe. Reads separated by idle gaps check that bit 6 holds, and cycle restarts check that it returns to 0. A busy fall that coincides with a write pulse checks that the count is cleared.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic {OP_PROGRAM = 1'b0, OP_ERASE = 1'b1} op_e;
  typedef enum logic {RGN_FLASH = 1'b0, RGN_EEPROM = 1'b1} rgn_e;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT = 6;
  localparam int unsigned ERR_BIT = 5;
endpackage

// File: rtl/opstat_pulse_cnt.sv
module opstat_pulse_cnt #(
  parameter int unsigned PGM_N = 4,
  parameter int unsigned ERS_N = 6,
  parameter int unsigned EE_N  = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic we_i,
  input  logic op_i,
  input  logic rgn_i,
  output logic valid_o
);
  import opstat_pkg::*;
  localparam int unsigned MAX_A = (PGM_N > ERS_N) ? PGM_N : ERS_N;
  localparam int unsigned MAX_N = (MAX_A > EE_N) ? MAX_A : EE_N;
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);

  logic [CNT_W-1:0] cnt_q, thr;
  logic busy_q;

  always_comb begin
    if (rgn_e'(rgn_i) == RGN_EEPROM) thr = CNT_W'(EE_N);
    else if (op_e'(op_i) == OP_ERASE) thr = CNT_W'(ERS_N);
    else thr = CNT_W'(PGM_N);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (busy_q && !busy_i) cnt_q <= '0;  // cycle ended
      else if (we_i && cnt_q != CNT_W'(MAX_N)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = busy_i && (cnt_q >= thr);

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_N)); // R7
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !busy_i) |=> (cnt_q == '0)); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(busy_q && !busy_i) && cnt_q != CNT_W'(MAX_N)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else if (!busy_i) tog_q <= 1'b0;  // ready for next cycle
    else if (rd_i) tog_q <= ~tog_q;
  end

  assign tog_o = tog_q;

  AST_TOG_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && rd_i) |=> (tog_q != $past(tog_q))); // R3
  AST_TOG_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !tog_q); // R3
  AST_TOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_i) |=> $stable(tog_q)); // R3
endmodule

// File: rtl/opstat_mux.sv
module opstat_mux
  import opstat_pkg::*;
(
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              err_i,
  input  logic              tog_i,
  input  logic [DATA_W-1:0] array_i,
  output logic [DATA_W-1:0] dq_o
);
  always_comb begin
    dq_o = array_i;
    if (valid_i) begin
      dq_o[POLL_BIT] = (op_e'(op_i) == OP_ERASE) ? 1'b0 : ~wdata_i[POLL_BIT];
      dq_o[TOG_BIT]  = tog_i;
      dq_o[ERR_BIT]  = err_i;
    end
  end
endmodule

// File: rtl/opstat_top.sv
module opstat_top #(
  parameter int unsigned PGM_N = 4,
  parameter int unsigned ERS_N = 6,
  parameter int unsigned EE_N  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic       op_i,
  input  logic       rgn_i,
  input  logic [7:0] wdata_i,
  input  logic       err_i,
  input  logic       rd_i,
  input  logic       we_i,
  input  logic [7:0] array_i,
  output logic [7:0] dq_o,
  output logic       valid_o,
  output logic       rb_no
);
  logic valid, tog;

  opstat_pulse_cnt #(.PGM_N(PGM_N), .ERS_N(ERS_N), .EE_N(EE_N)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .we_i(we_i),
    .op_i(op_i), .rgn_i(rgn_i), .valid_o(valid));

  opstat_toggle u_tog (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy_i), .rd_i(rd_i), .tog_o(tog));

  opstat_mux u_mux (
    .valid_i(valid), .op_i(op_i), .wdata_i(wdata_i), .err_i(err_i),
    .tog_i(tog), .array_i(array_i), .dq_o(dq_o));

  assign valid_o = valid;
  assign rb_no   = !(busy_i && rgn_i);

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (dq_o == array_i)); // R4
  AST_RB_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rb_no |-> (busy_i && rgn_i)); // R6
  AST_ERASE_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op_i) |-> !dq_o[7]); // R2
  AST_LOW_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (dq_o[4:0] == array_i[4:0])); // R8
endmodule

// File: tb/sim_opstat_top.sv
module sim_opstat_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic busy = 0, op = 0, rgn = 0, err = 0, rd = 0, we = 0;
  logic [7:0] wdata = 0, arr = 0;
  logic [7:0] dq;
  logic valid, rb_n;
  int checks = 0, fails = 0;
  int cnt_m = 0;
  logic tog_m = 0, busy_q_m = 0;
  bit done = 0;

  always #10 clk = ~clk;

  opstat_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .busy_i(busy), .op_i(op), .rgn_i(rgn),
    .wdata_i(wdata), .err_i(err), .rd_i(rd), .we_i(we), .array_i(arr),
    .dq_o(dq), .valid_o(valid), .rb_no(rb_n));

  function automatic int thr_f(logic o, logic r);
    if (r) return 1;
    return o ? 6 : 4;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive at negedge, check, then advance the reference state on posedge
  task automatic step(logic b, logic o, logic r, logic [7:0] wd, logic e,
                      logic rdv, logic wev, logic [7:0] a);
    logic ev;
    busy = b; op = o; rgn = r; wdata = wd; err = e; rd = rdv; we = wev; arr = a;
    #1;
    ev = b && (cnt_m >= thr_f(o, r));
    chk("R7 valid", {7'b0, valid}, {7'b0, ev});
    chk("R6 rb", {7'b0, rb_n}, {7'b0, !(b && r)});
    if (!b) chk("R4 idle", dq, a);
    else if (!ev) chk("R7 pre", dq, a);
    else begin
      chk(o ? "R2 bit7" : "R1 bit7", {7'b0, dq[7]}, {7'b0, o ? 1'b0 : ~wd[7]});
      chk("R3 bit6", {7'b0, dq[6]}, {7'b0, tog_m});
      chk("R5 bit5", {7'b0, dq[5]}, {7'b0, e});
      chk("R8 low", {3'b0, dq[4:0]}, {3'b0, a[4:0]});
    end
    @(posedge clk);
    if (busy_q_m && !b) cnt_m = 0;
    else if (wev && cnt_m < 6) cnt_m++;
    if (!b) tog_m = 0; else if (rdv) tog_m = ~tog_m;
    busy_q_m = b;
    @(negedge clk);
  endtask

  task automatic episode(logic o, logic r, int pulses, int busy_len);
    logic [7:0] wd;
    wd = 8'($urandom);
    for (int i = 0; i < pulses; i++) step(0, o, r, wd, 0, 0, 1, 8'($urandom));
    for (int i = 0; i < busy_len; i++)
      step(1, o, r, wd, 1'($urandom % 4 == 0), 1'($urandom % 2), 0, 8'($urandom));
    step(0, o, r, wd, 0, 1, 0, 8'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7193));
    busy = 0; arr = 8'hA5;
    @(negedge clk); @(negedge clk);
    // R9 reset state
    chk("R9 reset dq", dq, 8'hA5);
    chk("R9 reset valid", {7'b0, valid}, 8'h0);
    chk("R6 reset rb", {7'b0, rb_n}, 8'h1);
    rst_ni = 1'b1;
    @(negedge clk);
    // thresholds one short, then exact
    episode(0, 0, 3, 3); step(0,0,0,0,0,0,0,0);
    episode(0, 0, 4, 4);
    episode(1, 0, 5, 3);
    episode(1, 0, 6, 5);
    episode(0, 1, 0, 3);
    episode(1, 1, 1, 4);
    // back-to-back reads, then gaps (R3)
    for (int i = 0; i < 4; i++) step(0, 0, 0, 8'h80, 0, 0, 1, 8'h3C);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 8'h80, 0, 1, 0, 8'h3C);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 8'h80, 0, 0, 0, 8'h3C);
    // busy fall with a coinciding pulse clears count (R9)
    step(0, 0, 0, 8'h80, 0, 0, 1, 8'h3C);
    step(1, 0, 0, 8'h80, 0, 0, 0, 8'h3C);
    chk("R9 clear", {7'b0, valid}, 8'h0);
    // random episodes
    for (int k = 0; k < 300; k++)
      episode(1'($urandom), 1'($urandom), int'($urandom % 8), 1 + int'($urandom % 10));
    for (int k = 0; k < 2000; k++)
      step(1'($urandom % 3 != 0), 1'($urandom), 1'($urandom), 8'($urandom),
           1'($urandom % 5 == 0), 1'($urandom), 1'($urandom % 3 == 0), 8'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule